// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between the serial protocol engine of a byte-addressed nonvolatile memory and its storage array. While a write transaction is open, the engine hands it a starting address and then a stream of received data bytes. Each byte lands in a page-sized holding buffer at the position named by the low address bits. The pointer then advances inside the page and never leaves it, so an overlong transfer wraps around and overwrites its own earlier bytes. A per-location flag records which positions were filled.

When the engine reports the end-of-transfer condition and at least one byte is held, the block walks the whole page once. It issues one array write for every flagged location, in ascending order. It then runs a programmable timer so that the total busy period models the array's write time. The busy flag is raised for the scan and the timer together, and the engine uses it to refuse traffic. While the write-protect level is high at the end of a transfer, nothing is committed. A new start condition that comes before any end-of-transfer throws the held bytes away.

Top module: `page_commit_buffer`

## Requirements
- R1: A data byte is stored at the page location given by the low PAGE_BITS bits of the pointer, then only those low bits increment. The upper address bits stay as loaded by `addr_load`, and every committed address carries them unchanged.
- R2: Incrementing from location PAGE_BYTES-1 of a page gives location 0 of the same page.
- R3: When more than PAGE_BYTES bytes arrive in one transaction, each location keeps the last byte written to it.
- R4: `stop_pulse` with at least one byte held and `wp` low raises `busy` on the next cycle. `busy` then stays high for exactly PAGE_BYTES + WRITE_CYCLES cycles. Within that time every received location is written exactly once, in ascending location order, and no other location is written.
- R5: `stop_pulse` while `wp` is high produces no array write and no busy period, and the held bytes are discarded.
- R6: `stop_pulse` with no byte held produces no array write and no busy period.
- R7: `start_pulse` with no `stop_pulse` before it discards all held bytes, so a later `stop_pulse` commits nothing.
- R8: While `busy` is high, `addr_load`, `data_valid`, `start_pulse` and `stop_pulse` are ignored. No byte sent then is ever committed, and no second busy period follows.
- R9: After reset, `busy` and `mem_we` are low and no byte is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_pulse | input | 1 | One-cycle strobe: start condition seen on the bus |
| stop_pulse | input | 1 | One-cycle strobe: end-of-transfer condition seen |
| addr_load | input | 1 | One-cycle strobe: load `addr_in` into the pointer |
| addr_in | input | ADDR_W | Starting address of the write |
| data_valid | input | 1 | One-cycle strobe: `data_in` holds a received byte |
| data_in | input | DATA_W | Received data byte |
| wp | input | 1 | Write-protect level, high blocks every write |
| mem_we | output | 1 | Array write enable, one cycle per byte |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | High during the commit scan and the write timer |

## Verification
The main function is tried with a single byte, with a short burst that crosses the page end, and with a burst of PAGE_BYTES+2 bytes. These separate, in turn, a correct pointer and page base, a correct in-page wrap, and last-writer-wins overwriting. The other patterns are an end-of-transfer while protected, an end-of-transfer after only an address, and a start condition between the data and the end-of-transfer. Each of these must leave the array untouched and busy low. Traffic sent during a busy period, followed by a clean single-byte write, shows whether ignored bytes leak into later commits. The length of every busy period is counted against PAGE_BYTES+WRITE_CYCLES.

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 7,
  parameter int WRITE_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic              wp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);

  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WAIT} state_t;

  state_t                       st;
  logic [ADDR_W-1:PAGE_BITS]    page_q;
  logic [PAGE_BITS-1:0]         off_q;
  logic [PAGE_BITS-1:0]         scan_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [PAGE_BYTES-1:0]        held_q;
  logic [DATA_W-1:0]            pg_mem [PAGE_BYTES];

  wire idle     = (st == S_IDLE);
  wire take     = idle && !stop_pulse && !start_pulse && !addr_load && data_valid;
  wire any_held = |held_q;

  assign busy      = !idle;
  assign mem_we    = (st == S_SCAN) && held_q[scan_q];
  assign mem_addr  = {page_q, scan_q};
  assign mem_wdata = pg_mem[scan_q];

  always_ff @(posedge clk) begin
    if (take) pg_mem[off_q] <= data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      page_q <= '0;
      off_q  <= '0;
      scan_q <= '0;
      cnt_q  <= '0;
      held_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (stop_pulse) begin
            if (any_held && !wp) begin
              st     <= S_SCAN;
              scan_q <= '0;
            end else begin
              held_q <= '0;
            end
          end else if (start_pulse) begin
            held_q <= '0;
          end else if (addr_load) begin
            page_q <= addr_in[ADDR_W-1:PAGE_BITS];
            off_q  <= addr_in[PAGE_BITS-1:0];
          end else if (data_valid) begin
            held_q[off_q] <= 1'b1;
            off_q         <= off_q + 1'b1;
          end
        end
        S_SCAN: begin
          scan_q <= scan_q + 1'b1;
          if (scan_q == PAGE_BITS'(PAGE_BYTES - 1)) begin
            st    <= S_WAIT;
            cnt_q <= '0;
          end
        end
        S_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(WRITE_CYCLES - 1)) begin
            st     <= S_IDLE;
            held_q <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r4_busy_starts_with_scan: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (st == S_SCAN) && (scan_q == '0));

  a_r5_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_pulse && wp) |=> !busy);

  a_r6_empty_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_pulse && !any_held) |=> !busy);

  a_r8_held_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SCAN) && data_valid) |=> $stable(held_q));

  a_r1_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_q));

  a_r9_idle_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !any_held);

endmodule

// File: tb/page_commit_buffer_bench.sv
module page_commit_buffer_bench;
  localparam int ADDR_W = 16, DATA_W = 8, PAGE_BITS = 7, WRITE_CYCLES = 300;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_pulse = 0, stop_pulse = 0, addr_load = 0, data_valid = 0, wp = 0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [DATA_W-1:0] data_in = '0;
  logic mem_we, busy;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  int checks = 0, fails = 0;
  string cur_req = "R9";
  logic [ADDR_W+DATA_W-1:0] expq[$];

  logic [DATA_W-1:0] m_data [PAGE_BYTES];
  bit               m_held [PAGE_BYTES];
  logic [ADDR_W-1:0] m_ptr = '0;

  always #5 clk = ~clk;

  page_commit_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
    .WRITE_CYCLES(WRITE_CYCLES)) u_page_commit_buffer (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .addr_load(addr_load), .addr_in(addr_in), .data_valid(data_valid),
    .data_in(data_in), .wp(wp), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy));

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (expq.size() == 0) begin
        check(1'b0, "unexpected array write", {8'h0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = expq.pop_front();
        check({mem_addr, mem_wdata} == e, "array write addr/data", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_pulse = 1; @(negedge clk) start_pulse = 0;
    if (!busy) for (int i = 0; i < PAGE_BYTES; i++) m_held[i] = 0;
  endtask

  task automatic load(input logic [ADDR_W-1:0] a);
    bit b; b = busy;
    @(negedge clk) addr_load = 1; addr_in = a; @(negedge clk) addr_load = 0;
    if (!b) m_ptr = a;
  endtask

  task automatic send(input logic [DATA_W-1:0] d);
    bit b; b = busy;
    @(negedge clk) data_valid = 1; data_in = d; @(negedge clk) data_valid = 0;
    if (!b) begin
      m_data[m_ptr[PAGE_BITS-1:0]] = d;
      m_held[m_ptr[PAGE_BITS-1:0]] = 1;
      m_ptr[PAGE_BITS-1:0] = m_ptr[PAGE_BITS-1:0] + 1'b1;
    end
  endtask

  task automatic finish_stop();
    bit any; int n;
    any = 0;
    for (int i = 0; i < PAGE_BYTES; i++) if (m_held[i]) any = 1;
    if (any && !wp)
      for (int i = 0; i < PAGE_BYTES; i++)
        if (m_held[i]) expq.push_back({m_ptr[ADDR_W-1:PAGE_BITS], PAGE_BITS'(i), m_data[i]});
    for (int i = 0; i < PAGE_BYTES; i++) m_held[i] = 0;
    @(negedge clk) stop_pulse = 1; @(negedge clk) stop_pulse = 0;
    n = 0;
    while (busy && n < 4 * (PAGE_BYTES + WRITE_CYCLES)) begin n++; @(negedge clk); end
    check(n == ((any && !wp) ? PAGE_BYTES + WRITE_CYCLES : 0), "busy length", n,
          (any && !wp) ? PAGE_BYTES + WRITE_CYCLES : 0);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "pending expected writes", expq.size(), 0);
    check(!busy, "busy after commit window", busy, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGE_BYTES; i++) m_held[i] = 0;
    repeat (3) @(negedge clk);
    cur_req = "R9";
    check(busy == 0, "busy in reset", busy, 0);
    check(mem_we == 0, "mem_we in reset", mem_we, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(busy == 0 && mem_we == 0, "idle after reset", {busy, mem_we}, 0);

    cur_req = "R1";
    pulse_start(); load(16'h1234); send(8'hA5); finish_stop();

    cur_req = "R2";
    pulse_start(); load(16'h127E);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44); finish_stop();

    cur_req = "R3";
    pulse_start(); load(16'h0500);
    for (int i = 0; i < PAGE_BYTES + 2; i++) send(DATA_W'(i * 7 + 3));
    finish_stop();

    cur_req = "R5";
    pulse_start(); load(16'h2000); send(8'h5A); send(8'h6B);
    wp = 1; finish_stop(); wp = 0;
    finish_stop();

    cur_req = "R6";
    pulse_start(); load(16'h3000); finish_stop();

    cur_req = "R7";
    pulse_start(); load(16'h4000); send(8'h77); pulse_start(); finish_stop();

    cur_req = "R8";
    pulse_start(); load(16'h6010); send(8'hC3);
    expq.push_back({16'h6010, 8'hC3});
    for (int i = 0; i < PAGE_BYTES; i++) m_held[i] = 0;
    @(negedge clk) stop_pulse = 1; @(negedge clk) stop_pulse = 0;
    check(busy == 1, "busy after stop", busy, 1);
    load(16'h7000); send(8'hEE); send(8'hEF); pulse_start();
    @(negedge clk) stop_pulse = 1; @(negedge clk) stop_pulse = 0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check(!busy, "no second busy period", busy, 0);
    check(expq.size() == 0, "ignored traffic commit", expq.size(), 0);
    pulse_start(); send(8'h9D); finish_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule